// File: doc/BRIEF.md
# Configuration byte streamer

This block loads a programmable-logic target from an image held in a byte-wide source memory. On a start request it pulses a reset to the target, lets a programmable settle time elapse, and writes one filler byte. It then reads a 16-byte image header, takes the payload length from its first four bytes, streams that many payload bytes to the target's configuration data port (one byte per write strobe, on consecutive cycles) and closes the stream with filler bytes.

Once the stream is closed, the block samples the target's error line a single time. A raised line ends the run as a failure at once. Otherwise a programmable ready time elapses before the run is reported as a success. The result flags stay put until the next start. The source memory has an asynchronous read: `mem_data_i` must carry the byte at `mem_addr_o` within the same cycle.

Top module: `cfgs_streamer`

## Requirements
- R1: After reset, busy_o, done_o, error_o, cfg_wr_o and cfg_reset_o are all low.
- R2: A start_i seen high at a clock edge while idle gives a cfg_reset_o pulse exactly one cycle wide in the following cycle. The first write strobe comes exactly SETTLE_CYC+1 cycles after that pulse cycle, with no strobe in between, and there is one reset pulse per run.
- R3: The first byte written in a run is a single filler byte of value 0x00.
- R4: Image bytes 0..3 hold the payload length L as an unsigned 32-bit big-endian value (byte 0 most significant). Bytes 4..15 have no effect on what is written.
- R5: After the filler, L write strobes follow on consecutive cycles, and the i-th one carries image byte 16+i.
- R6: When L is 0, the stream goes straight from the leading filler to the trailing fillers (6 writes in total).
- R7: The payload is followed by exactly five writes of 0x00, so a run makes L+6 writes in all.
- R8: cfg_err_i is sampled only in the cycle right after the last trailing filler. If it is high there, done_o and error_o both rise 2 cycles after the last write cycle. Its value at any other time has no effect.
- R9: On success, done_o rises with error_o low, READY_CYC+2 cycles after the last write cycle.
- R10: busy_o is high from the cycle after an accepted start until done_o rises. No strobe or reset pulse occurs while idle, and a start_i while busy is ignored.
- R11: done_o and error_o hold their value while idle until the next start, which clears both in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a load (taken only while idle) |
| mem_addr_o | output | ADDR_W | Source memory byte address |
| mem_data_i | input | 8 | Source memory byte at mem_addr_o (same cycle) |
| cfg_reset_o | output | 1 | One-cycle reset pulse to the target |
| cfg_wr_o | output | 1 | Configuration byte write strobe |
| cfg_data_o | output | 8 | Configuration byte |
| cfg_err_i | input | 1 | Target error line |
| busy_o | output | 1 | Load in progress |
| done_o | output | 1 | Last load finished |
| error_o | output | 1 | Last load failed |

## Verification
The assertions take for granted a clean reset release. They also assume that start_i is a plain level, sampled at clock edges, which may be raised at any time, including while a load is running. The stimulus changes start_i and cfg_err_i only on falling clock edges. It raises start_i during a busy run to exercise the ignore rule, and holds cfg_err_i in several patterns: low throughout, high throughout, high everywhere except the sampling cycle, and high only from the sampling cycle on. The bench memory answers reads combinationally, which meets the same-cycle read that the block assumes.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_RST, ST_SETTLE, ST_LEAD, ST_HDR,
    ST_PAY, ST_TAIL, ST_CHK, ST_READY
  } cfgs_state_e;

  localparam int unsigned HDR_LEN_BYTES = 4;
  localparam int unsigned LEN_W         = 8 * HDR_LEN_BYTES;
  localparam int unsigned PAYLOAD_OFS   = 16;
  localparam int unsigned TAIL_FILLS    = 5;
  localparam logic [7:0]  FILL_BYTE     = 8'h00;
endpackage

// File: rtl/cfgs_wait_timer.sv
module cfgs_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             en_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= load_val_i;
    else if (en_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/cfgs_len_capture.sv
module cfgs_len_capture #(
  parameter int unsigned NBYTES = 4,
  localparam int unsigned IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cap_i,
  input  logic [IDX_W-1:0]    idx_i,
  input  logic [7:0]          byte_i,
  output logic [8*NBYTES-1:0] len_o,
  output logic [8*NBYTES-1:0] len_now_o
);
  // byte 0 of the header is the most significant
  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    logic [7:0] byte_q;
    logic       hit;
    assign hit = cap_i && (idx_i == IDX_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  byte_q <= '0;
      else if (hit) byte_q <= byte_i;
    end

    assign len_o[8*(NBYTES-1-k) +: 8] = byte_q;
    if (k == NBYTES - 1) begin : g_last
      assign len_now_o[7:0] = hit ? byte_i : byte_q;
    end else begin : g_other
      assign len_now_o[8*(NBYTES-1-k) +: 8] = byte_q;
    end
  end
endmodule

// File: rtl/cfgs_out_drv.sv
module cfgs_out_drv import cfgs_pkg::*; #(
  parameter int unsigned ADDR_W = 16
) (
  input  cfgs_state_e       state_i,
  input  logic [LEN_W-1:0]  cnt_i,
  input  logic [7:0]        mem_data_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              cfg_reset_o,
  output logic              cfg_wr_o,
  output logic [7:0]        cfg_data_o
);
  logic [LEN_W-1:0] pay_addr;
  assign pay_addr = cnt_i + LEN_W'(PAYLOAD_OFS);

  always_comb begin
    mem_addr_o  = '0;
    cfg_reset_o = 1'b0;
    cfg_wr_o    = 1'b0;
    cfg_data_o  = FILL_BYTE;
    unique case (state_i)
      ST_RST:  cfg_reset_o = 1'b1;
      ST_HDR:  mem_addr_o  = ADDR_W'(cnt_i);
      ST_LEAD, ST_TAIL: cfg_wr_o = 1'b1;
      ST_PAY: begin
        mem_addr_o = ADDR_W'(pay_addr);
        cfg_wr_o   = 1'b1;
        cfg_data_o = mem_data_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cfgs_streamer.sv
module cfgs_streamer import cfgs_pkg::*; #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned SETTLE_CYC = 1000,
  parameter int unsigned READY_CYC  = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [7:0]        mem_data_i,
  output logic              cfg_reset_o,
  output logic              cfg_wr_o,
  output logic [7:0]        cfg_data_o,
  input  logic              cfg_err_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o
);
  localparam int unsigned WAIT_MAX  = (SETTLE_CYC > READY_CYC) ? SETTLE_CYC : READY_CYC;
  localparam int unsigned WAIT_W    = (WAIT_MAX > 1) ? $clog2(WAIT_MAX) : 1;
  localparam int unsigned IDX_W     = (HDR_LEN_BYTES > 1) ? $clog2(HDR_LEN_BYTES) : 1;
  localparam logic [WAIT_W-1:0] SETTLE_LD = WAIT_W'(SETTLE_CYC - 1);
  localparam logic [WAIT_W-1:0] READY_LD  = WAIT_W'(READY_CYC - 1);
  localparam logic [LEN_W-1:0]  HDR_LAST  = LEN_W'(HDR_LEN_BYTES - 1);
  localparam logic [LEN_W-1:0]  TAIL_LAST = LEN_W'(TAIL_FILLS - 1);

  cfgs_state_e      state_q, state_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d, err_q, err_d;
  logic [LEN_W-1:0] len_q, len_now;
  logic             wait_zero;

  cfgs_wait_timer #(.CNT_W(WAIT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (state_q == ST_RST || state_q == ST_CHK),
    .load_val_i ((state_q == ST_RST) ? SETTLE_LD : READY_LD),
    .en_i       (state_q == ST_SETTLE || state_q == ST_READY),
    .zero_o     (wait_zero)
  );

  cfgs_len_capture #(.NBYTES(HDR_LEN_BYTES)) u_len (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_i     (state_q == ST_HDR),
    .idx_i     (cnt_q[IDX_W-1:0]),
    .byte_i    (mem_data_i),
    .len_o     (len_q),
    .len_now_o (len_now)
  );

  cfgs_out_drv #(.ADDR_W(ADDR_W)) u_out (
    .state_i     (state_q),
    .cnt_i       (cnt_q),
    .mem_data_i  (mem_data_i),
    .mem_addr_o  (mem_addr_o),
    .cfg_reset_o (cfg_reset_o),
    .cfg_wr_o    (cfg_wr_o),
    .cfg_data_o  (cfg_data_o)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    err_d   = err_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RST;
        cnt_d   = '0;
        done_d  = 1'b0;
        err_d   = 1'b0;
      end
      ST_RST:    state_d = ST_SETTLE;
      ST_SETTLE: if (wait_zero) state_d = ST_LEAD;
      ST_LEAD: begin
        state_d = ST_HDR;
        cnt_d   = '0;
      end
      ST_HDR: begin
        if (cnt_q == HDR_LAST) begin
          cnt_d   = '0;
          state_d = (len_now == '0) ? ST_TAIL : ST_PAY;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAY: begin
        if (cnt_q == len_q - 1'b1) begin
          cnt_d   = '0;
          state_d = ST_TAIL;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TAIL: begin
        if (cnt_q == TAIL_LAST) state_d = ST_CHK;
        else                    cnt_d   = cnt_q + 1'b1;
      end
      ST_CHK: begin
        if (cfg_err_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          err_d   = 1'b1;
        end else begin
          state_d = ST_READY;
        end
      end
      ST_READY: if (wait_zero) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
  assign error_o = err_q;
endmodule

// File: rtl/cfgs_streamer_chk.sv
module cfgs_streamer_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       cfg_reset_o,
  input logic       cfg_wr_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       error_o
);
  assert_quiet_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cfg_wr_o && !cfg_reset_o));

  assert_busy_needs_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_rst_one_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reset_o |=> !cfg_reset_o);

  assert_rst_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_reset_o |-> !cfg_wr_o);

  assert_result_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(done_o) && $stable(error_o)));

  assert_error_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

bind cfgs_streamer cfgs_streamer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cfg_reset_o (cfg_reset_o),
  .cfg_wr_o    (cfg_wr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .error_o     (error_o)
);

// File: tb/cfgs_streamer_test.sv
module cfgs_streamer_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 3;
  localparam int READY      = 4;
  localparam int NVEC       = 6;
  localparam int VEC_LEN  [NVEC] = '{1, 3, 0, 7, 2, 12};
  localparam int VEC_ERR  [NVEC] = '{0, 0, 0, 1, 1, 0};
  localparam int VEC_SEED [NVEC] = '{8'h5A, 8'h13, 8'hC7, 8'h81, 8'h3E, 8'hF0};

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_data_i;
  logic        cfg_reset_o, cfg_wr_o, cfg_err_i, busy_o, done_o, error_o;
  logic [7:0]  cfg_data_o;

  logic [7:0] mem [512];
  logic [7:0] got [512];
  int nwr, rst_cnt, rst_cyc, first_wr, last_wr, cyc, exp_total, err_mode;
  int n_tests = 0, n_fail = 0;
  bit mon_en = 0;

  cfgs_streamer #(.ADDR_W(16), .SETTLE_CYC(SETTLE), .READY_CYC(READY)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .mem_addr_o(mem_addr_o), .mem_data_i(mem_data_i),
    .cfg_reset_o(cfg_reset_o), .cfg_wr_o(cfg_wr_o), .cfg_data_o(cfg_data_o),
    .cfg_err_i(cfg_err_i), .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;
  assign mem_data_i = mem[mem_addr_o[8:0]];

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // negedge monitor: records strobes and steers the error line
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (cfg_wr_o) begin
        if (nwr == 0) first_wr = cyc;
        got[nwr] = cfg_data_o;
        nwr++;
        last_wr = cyc;
      end
      if (cfg_reset_o) begin
        rst_cnt++;
        rst_cyc = cyc;
      end
      if (err_mode == 2 && nwr == exp_total) cfg_err_i = 1'b0;
      if (err_mode == 3 && nwr == exp_total) cfg_err_i = 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pay_byte(int seed, int i);
    return 8'(seed ^ (i * 37));
  endfunction

  // err_mode: 0 low, 1 high always, 2 high except check cycle, 3 high only from check cycle
  task automatic run_image(input int len, input int seed, input int mode, input bit poke);
    int done_cyc, lim, bad_pay, bad_tail;
    bit exp_err;
    mem[0] = 8'(len >> 24); mem[1] = 8'(len >> 16);
    mem[2] = 8'(len >> 8);  mem[3] = 8'(len);
    for (int k = 4; k < 16; k++) mem[k] = 8'(8'hA5 + k * 11);  // R4 reserved junk
    for (int i = 0; i < len; i++) mem[16 + i] = pay_byte(seed, i);
    nwr = 0; rst_cnt = 0; rst_cyc = -1; first_wr = -1; last_wr = -1;
    exp_total = len + 6;
    err_mode = mode;
    cfg_err_i = (mode == 1 || mode == 2);
    exp_err = (mode == 1 || mode == 3);
    mon_en = 1;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    check(busy_o == 1'b1, "R10 busy after start", int'(busy_o), 1);
    check(done_o == 1'b0 && error_o == 1'b0, "R11 start clears result",
          int'({done_o, error_o}), 0);
    if (poke) begin
      repeat (12) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
    end
    lim = 0;
    while (!(done_o && !busy_o) && lim < 5000) begin
      @(negedge clk_i); lim++;
    end
    done_cyc = cyc;
    mon_en = 0;
    cfg_err_i = 1'b0;
    check(rst_cnt == 1, "R2 reset pulse count", rst_cnt, 1);
    check(first_wr - rst_cyc == SETTLE + 1, "R2 settle gap", first_wr - rst_cyc, SETTLE + 1);
    check(nwr == len + 6, "R7 write count", nwr, len + 6);
    check(got[0] == 8'h00, "R3 leading filler", int'(got[0]), 0);
    bad_pay = 0;
    for (int i = 0; i < len && i + 1 < 512; i++)
      if (got[1 + i] !== pay_byte(seed, i)) bad_pay++;
    check(bad_pay == 0, "R5 payload bytes mismatched", bad_pay, 0);
    bad_tail = 0;
    for (int i = 0; i < 5; i++)
      if (nwr < len + 6 || got[len + 1 + i] !== 8'h00) bad_tail++;
    check(bad_tail == 0, "R7 trailing fillers bad", bad_tail, 0);
    check(error_o == exp_err, "R8 error result", int'(error_o), int'(exp_err));
    if (exp_err)
      check(done_cyc - last_wr == 2, "R8 done after fail", done_cyc - last_wr, 2);
    else
      check(done_cyc - last_wr == READY + 2, "R9 done after ready wait",
            done_cyc - last_wr, READY + 2);
  endtask

  initial begin
    cfg_err_i = 1'b0;
    for (int k = 0; k < 512; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !error_o && !cfg_wr_o && !cfg_reset_o, "R1 reset state",
          int'({busy_o, done_o, error_o, cfg_wr_o, cfg_reset_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !done_o && !error_o, "R1 after release",
          int'({busy_o, done_o, error_o}), 0);

    for (int v = 0; v < NVEC; v++)
      run_image(VEC_LEN[v], VEC_SEED[v], VEC_ERR[v], 1'b0);

    // R6 zero length: only fillers
    run_image(0, 8'h22, 0, 1'b0);
    check(nwr == 6, "R6 zero length writes", nwr, 6);

    // R4 big-endian: length 0x00000103
    run_image(32'h0000_0103, 8'h9C, 0, 1'b0);
    check(nwr == 259 + 6, "R4 big-endian length", nwr, 265);

    // R8 error high everywhere but the sampling cycle -> success
    run_image(5, 8'h44, 2, 1'b0);
    // R8 error raised only at the sampling cycle -> failure
    run_image(4, 8'h66, 3, 1'b0);

    // R11 result held while idle
    repeat (15) @(negedge clk_i);
    check(done_o && error_o, "R11 result held idle", int'({done_o, error_o}), 3);

    // R10 start while busy ignored
    run_image(20, 8'h77, 0, 1'b1);
    repeat (6) @(negedge clk_i);
    check(!busy_o && done_o, "R10 no restart from busy start",
          int'({busy_o, done_o}), 1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule